// File: doc/BRIEF.md
# Flag-Setting Integer ALU with Condition Gating

This block is the 32-bit integer data-processing unit of a small processor core. Each cycle it receives one operation. The operation carries a first operand from a register and a second operand, which is either a register or a 12-bit unsigned immediate. It also carries a 4-bit opcode, a set-flags request and a 4-bit condition code. The block computes the result combinationally and decides whether the destination write happens. It keeps the N/Z/C/V status in a clocked register. Five arithmetic forms use carry-in and inverted-borrow semantics, so a chain of operations builds sums and differences wider than one word. The five logical forms include bit-clear and OR-with-complement.

The condition code is tested against the flags currently held in the register. If the test fails, the operation has no architectural effect: there is no write and no flag change. Two inputs mark the program counter. One says the first operand is the program counter; that operand is then word-aligned before use, and the block enforces the restrictions that apply to that case. The other says the destination is the program counter; the written address then has bit 0 cleared, and a branch is signalled.

Top module: `flag_alu`

## Requirements
- R1: The arithmetic opcodes compute, with b the selected second operand and C the held carry: 0 is a+b, 1 is a+b+C, 2 is a-b, 3 is a-b-(1-C), and 4 is b-a. All results are modulo 2^32.
- R2: The logical opcodes compute: 5 is a AND b, 6 is a OR b, 7 is a XOR b, 8 is a AND NOT b, and 9 is a OR NOT b. When `use_imm` is 1, b is `imm12` zero-extended; otherwise b is `rm`.
- R3: The flag register `flags` = {N,Z,C,V} (bit 3 down to bit 0) changes only after an operation with `set_flags`=1 and `wr_en`=1. In every other cycle outside reset it keeps its value.
- R4: Arithmetic with flags set loads the following. N is result bit 31 and Z is 1 when the result is zero. C is the carry out of an add, or 1 when a subtract, subtract-with-carry or reverse subtract needs no borrow. V is 1 on signed overflow.
- R5: Logical operations with flags set update N and Z from the result and leave C and V unchanged.
- R6: A flag-setting add of the low words followed by an add-with-carry of the high words yields the correct 64-bit sum. A flag-setting subtract followed by two subtract-with-carry operations yields the correct 96-bit difference.
- R7: When `rn_is_pc`=1, bits [1:0] of the first operand are taken as zero before the operation.
- R8: `illegal` is 1 in two cases. The first is an opcode of 10 to 15. The second is `rn_is_pc`=1 together with an opcode other than 0 or 2, `use_imm`=0, or `set_flags`=1. An illegal operation drives `wr_en` to 0 and leaves the flags unchanged.
- R9: When `rd_is_pc`=1 and the write happens, `result` has bit 0 forced to 0 and `branch_taken` is 1. Otherwise `branch_taken` is 0.
- R10: The condition codes are 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), and 14 and 15 always. A failing condition gives `wr_en`=0 and leaves the flags unchanged.
- R11: A synchronous active-high `rst` clears all four flags to 0 at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op | input | 4 | Operation code |
| set_flags | input | 1 | Request to update N/Z/C/V |
| cond | input | 4 | Condition code |
| rn | input | 32 | First operand |
| rm | input | 32 | Register second operand |
| imm12 | input | 12 | Immediate second operand |
| use_imm | input | 1 | Select the immediate as second operand |
| rn_is_pc | input | 1 | First operand is the program counter |
| rd_is_pc | input | 1 | Destination is the program counter |
| result | output | 32 | Computed value (bit 0 cleared for a PC destination) |
| wr_en | output | 1 | Destination write enable |
| branch_taken | output | 1 | Write to the program counter takes place |
| illegal | output | 1 | Operation breaks an encoding rule |
| flags | output | 4 | {N,Z,C,V} |

## Verification
The assertions cover the rules that hold in every cycle. The flags stay put without an enabled flag-setting write. Illegal and condition-failed operations are blocked. A logical operation preserves C and V. A branch address is even, and a write that passes condition 8 sees C set and Z clear. The actual values cannot be checked by a property that stands apart from the logic. These include arithmetic and logical results, carry and overflow edge values, operand alignment, and the multiword chains. The bench model checks them against wide integer arithmetic in directed and random scenarios.

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int W    = 32,
  parameter int IMMW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    op,
  input  logic          set_flags,
  input  logic [3:0]    cond,
  input  logic [W-1:0]  rn,
  input  logic [W-1:0]  rm,
  input  logic [IMMW-1:0] imm12,
  input  logic          use_imm,
  input  logic          rn_is_pc,
  input  logic          rd_is_pc,
  output logic [W-1:0]  result,
  output logic          wr_en,
  output logic          branch_taken,
  output logic          illegal,
  output logic [3:0]    flags
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2,
                         OP_SBC = 4'd3, OP_RSB = 4'd4, OP_AND = 4'd5,
                         OP_ORR = 4'd6, OP_EOR = 4'd7, OP_BIC = 4'd8,
                         OP_ORN = 4'd9;

  logic fn, fz, fc, fv;
  assign {fn, fz, fc, fv} = flags;

  logic [W-1:0] opa, opb, add_x, add_y, raw;
  logic         add_cin, is_arith, cpass;
  logic [W:0]   sum;

  assign opa = rn_is_pc ? {rn[W-1:2], 2'b00} : rn;
  assign opb = use_imm ? {{(W-IMMW){1'b0}}, imm12} : rm;

  always_comb begin
    add_x = opa; add_y = opb; add_cin = 1'b0;
    case (op)
      OP_ADC:  add_cin = fc;
      OP_SUB:  begin add_y = ~opb; add_cin = 1'b1; end
      OP_SBC:  begin add_y = ~opb; add_cin = fc;   end
      OP_RSB:  begin add_x = opb; add_y = ~opa; add_cin = 1'b1; end
      default: ;
    endcase
  end

  assign sum      = {1'b0, add_x} + {1'b0, add_y} + {{W{1'b0}}, add_cin};
  assign is_arith = (op <= OP_RSB);

  always_comb begin
    case (op)
      OP_AND:  raw = opa & opb;
      OP_ORR:  raw = opa | opb;
      OP_EOR:  raw = opa ^ opb;
      OP_BIC:  raw = opa & ~opb;
      OP_ORN:  raw = opa | ~opb;
      default: raw = sum[W-1:0];
    endcase
  end

  always_comb begin
    case (cond)
      4'd0:    cpass = fz;
      4'd1:    cpass = !fz;
      4'd2:    cpass = fc;
      4'd3:    cpass = !fc;
      4'd4:    cpass = fn;
      4'd5:    cpass = !fn;
      4'd6:    cpass = fv;
      4'd7:    cpass = !fv;
      4'd8:    cpass = fc && !fz;
      4'd9:    cpass = !fc || fz;
      4'd10:   cpass = (fn == fv);
      4'd11:   cpass = (fn != fv);
      4'd12:   cpass = !fz && (fn == fv);
      4'd13:   cpass = fz || (fn != fv);
      default: cpass = 1'b1;
    endcase
  end

  assign illegal = (op > OP_ORN) ||
                   (rn_is_pc && (!(op == OP_ADD || op == OP_SUB) || !use_imm || set_flags));
  assign wr_en        = cpass && !illegal;
  assign branch_taken = wr_en && rd_is_pc;
  assign result       = rd_is_pc ? {raw[W-1:1], 1'b0} : raw;

  logic ovf;
  assign ovf = (add_x[W-1] == add_y[W-1]) && (sum[W-1] != add_x[W-1]);

  always_ff @(posedge clk) begin
    if (rst)
      flags <= 4'b0000;
    else if (wr_en && set_flags)
      flags <= {raw[W-1], raw == '0,
                is_arith ? sum[W] : fc,
                is_arith ? ovf    : fv};
  end
endmodule

module flag_alu_sva (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  op,
  input logic        set_flags,
  input logic [3:0]  cond,
  input logic        wr_en,
  input logic        branch_taken,
  input logic        illegal,
  input logic [31:0] result,
  input logic [3:0]  flags
);
  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
    !set_flags |=> $stable(flags)); // R3
  AST_BLOCKED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(flags)); // R10
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !wr_en); // R8
  AST_BRANCH_EVEN: assert property (@(posedge clk) disable iff (rst)
    branch_taken |-> (wr_en && !result[0])); // R9
  AST_LOGIC_KEEPS_CV: assert property (@(posedge clk) disable iff (rst)
    (wr_en && set_flags && op >= 4'd5) |=> (flags[1:0] == $past(flags[1:0]))); // R5
  AST_HI_GATE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && cond == 4'd8) |-> (flags[1] && !flags[2])); // R10
endmodule

bind flag_alu flag_alu_sva u_sva (
  .clk(clk), .rst(rst), .op(op), .set_flags(set_flags), .cond(cond),
  .wr_en(wr_en), .branch_taken(branch_taken), .illegal(illegal),
  .result(result), .flags(flags)
);

// File: tb/tb_flag_alu.sv
module tb_flag_alu;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  op, cond;
  logic        set_flags, use_imm, rn_is_pc, rd_is_pc;
  logic [31:0] rn, rm;
  logic [11:0] imm12;
  logic [31:0] result;
  logic        wr_en, branch_taken, illegal;
  logic [3:0]  flags;

  int checks = 0;
  int fails  = 0;
  logic [3:0]  mf;
  logic [31:0] last_res;

  always #10 clk = ~clk;

  flag_alu dut (
    .clk(clk), .rst(rst), .op(op), .set_flags(set_flags), .cond(cond),
    .rn(rn), .rm(rm), .imm12(imm12), .use_imm(use_imm),
    .rn_is_pc(rn_is_pc), .rd_is_pc(rd_is_pc), .result(result),
    .wr_en(wr_en), .branch_taken(branch_taken), .illegal(illegal),
    .flags(flags)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit cond_ok(input logic [3:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      0: return z;            1: return !z;
      2: return cy;           3: return !cy;
      4: return n;            5: return !n;
      6: return v;            7: return !v;
      8: return cy && !z;     9: return !cy || z;
      10: return n == v;      11: return n != v;
      12: return !z && n == v; 13: return z || n != v;
      default: return 1;
    endcase
  endfunction

  task automatic step(input logic [3:0] o, input bit s, input logic [3:0] c,
                      input logic [31:0] a_in, input logic [31:0] m_in,
                      input logic [11:0] im, input bit ui, input bit apc,
                      input bit dpc, input string tag);
    longint ua, ub, sa, sb, r, sv;
    logic [31:0] a, b, er, eres;
    bit ec, ev, ill, we, ar, bor;
    @(negedge clk);
    op = o; set_flags = s; cond = c; rn = a_in; rm = m_in; imm12 = im;
    use_imm = ui; rn_is_pc = apc; rd_is_pc = dpc;
    a = apc ? (a_in & 32'hFFFF_FFFC) : a_in;
    b = ui ? {20'd0, im} : m_in;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ec = mf[1]; ev = mf[0]; ar = (o <= 4); r = 0; sv = 0;
    case (o)
      0: begin r = ua + ub; sv = sa + sb; ec = r[32]; end
      1: begin r = ua + ub + longint'(mf[1]); sv = sa + sb + longint'(mf[1]); ec = r[32]; end
      2: begin r = ua - ub; sv = sa - sb; ec = (ua >= ub); end
      3: begin bor = !mf[1]; r = ua - ub - longint'(bor); sv = sa - sb - longint'(bor);
               ec = (ua >= ub + longint'(bor)); end
      4: begin r = ub - ua; sv = sb - sa; ec = (ub >= ua); end
      5: r = ua & ub;
      6: r = ua | ub;
      7: r = ua ^ ub;
      8: r = longint'(a & ~b);
      9: r = longint'(a | ~b);
      default: r = 0;
    endcase
    er = r[31:0];
    if (ar) ev = (sv > 64'sd2147483647) || (sv < -64'sd2147483648);
    ill = (o > 9) || (apc && (!(o == 0 || o == 2) || !ui || s));
    we = cond_ok(c, mf) && !ill;
    eres = dpc ? (er & 32'hFFFF_FFFE) : er;
    #2;
    chk(illegal == ill, {tag, " R8 illegal"}, {31'd0, illegal}, {31'd0, ill});
    chk(wr_en == we, {tag, " R10 wr_en"}, {31'd0, wr_en}, {31'd0, we});
    chk(branch_taken == (we && dpc), {tag, " R9 branch"}, {31'd0, branch_taken}, {31'd0, we && dpc});
    if (we) chk(result == eres, {tag, " R1/R2 result"}, result, eres);
    last_res = result;
    if (we && s) mf = {er[31], er == 32'd0, ec, ev};
    @(posedge clk); #1;
    chk(flags == mf, {tag, " R3 flags"}, {28'd0, flags}, {28'd0, mf});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] lo, mid, hi;
    rst = 1'b1; op = 0; set_flags = 0; cond = 4'd14; rn = 0; rm = 0; imm12 = 0;
    use_imm = 0; rn_is_pc = 0; rd_is_pc = 0;
    repeat (2) @(posedge clk); #1;
    mf = 4'b0000;
    chk(flags == 4'b0000, "R11 reset clears flags", {28'd0, flags}, 32'd0);
    @(negedge clk); rst = 1'b0;

    // R1 R4: arithmetic and flags
    step(0, 1, 14, 32'h7FFF_FFFF, 32'd1, 0, 0, 0, 0, "R4 add overflow");
    chk(flags == 4'b1001, "R4 add ovf NV", {28'd0, flags}, 32'h9);
    step(0, 1, 14, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0, "R4 add carry zero");
    chk(flags == 4'b0110, "R4 add ZC", {28'd0, flags}, 32'h6);
    step(2, 1, 14, 32'd5, 32'd5, 0, 0, 0, 0, "R4 sub equal no borrow");
    chk(flags == 4'b0110, "R4 sub ZC", {28'd0, flags}, 32'h6);
    step(4, 1, 14, 32'd240, 32'd0, 12'd1280 >> 0, 1, 0, 0, "R1 rsb imm");
    chk(last_res == 32'd1040, "R1 rsb value", last_res, 32'd1040);
    step(2, 1, 14, 32'd3, 32'd4, 0, 0, 0, 0, "R4 sub borrow");
    chk(flags[1] == 1'b0, "R4 borrow clears C", {31'd0, flags[1]}, 32'd0);
    step(3, 0, 14, 32'd10, 32'd3, 0, 0, 0, 0, "R1 sbc borrow in");
    chk(last_res == 32'd6, "R1 sbc value", last_res, 32'd6);

    // R3: no flag update when set_flags clear
    step(0, 0, 14, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, 0, "R3 no S");

    // R2 R5: logical ops keep C and V
    step(0, 1, 14, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0, "R5 setup C");
    step(8, 1, 14, 32'hF0F0_F0F0, 32'hF000_0000, 0, 0, 0, 0, "R2 bic");
    chk(last_res == 32'h00F0_F0F0 && flags == 4'b0010, "R5 bic keeps C", {28'd0, flags}, 32'h2);
    step(9, 1, 14, 32'd0, 32'h0000_FFFF, 0, 0, 0, 0, "R2 orn");
    chk(last_res == 32'hFFFF_0000, "R2 orn value", last_res, 32'hFFFF_0000);
    step(7, 1, 14, 32'h1234_5678, 32'h1234_5678, 0, 0, 0, 0, "R2 eor zero");
    step(5, 0, 14, 32'hFF00, 32'h0FF0, 0, 0, 0, 0, "R2 and");
    step(6, 0, 14, 32'hFF00, 32'h0FF0, 0, 0, 0, 0, "R2 orr");

    // R6: 64-bit add chain
    step(0, 1, 14, 32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 0, 0, "R6 add lo"); lo = last_res;
    step(1, 0, 14, 32'h0000_0001, 32'h0000_0002, 0, 0, 0, 0, "R6 adc hi"); hi = last_res;
    chk({hi, lo} == 64'h4_0000_0000 ? 1'b1 : 1'b0, "R6 64-bit sum", hi, 32'd4);
    // R6: 96-bit subtract chain
    step(2, 1, 14, 32'd0, 32'd1, 0, 0, 0, 0, "R6 sub lo"); lo = last_res;
    step(3, 1, 14, 32'd0, 32'd0, 0, 0, 0, 0, "R6 sbc mid"); mid = last_res;
    step(3, 0, 14, 32'd5, 32'd1, 0, 0, 0, 0, "R6 sbc hi"); hi = last_res;
    chk(hi == 32'd3 && mid == 32'hFFFF_FFFF && lo == 32'hFFFF_FFFF, "R6 96-bit diff", hi, 32'd3);

    // R7 R8 R9: program counter rules
    step(0, 0, 14, 32'h0000_1003, 32'd0, 12'd4, 1, 1, 0, "R7 pc add");
    chk(last_res == 32'h0000_1004, "R7 pc aligned", last_res, 32'h1004);
    step(2, 0, 14, 32'h0000_2002, 32'd0, 12'd2, 1, 1, 0, "R7 pc sub");
    step(0, 0, 14, 32'h100, 32'd8, 0, 0, 1, 0, "R8 pc reg operand");
    step(0, 1, 14, 32'h100, 32'd0, 12'd8, 1, 1, 0, "R8 pc with S");
    step(5, 0, 14, 32'h100, 32'd0, 12'd8, 1, 1, 0, "R8 pc logical");
    step(12, 1, 14, 32'h1, 32'h1, 0, 0, 0, 0, "R8 undefined op");
    step(0, 0, 14, 32'h2000, 32'h0000_0011, 0, 0, 0, 1, "R9 branch");
    chk(last_res == 32'h0000_2010, "R9 bit0 cleared", last_res, 32'h2010);

    // R10: every condition under several flag states
    for (int k = 0; k < 4; k++) begin
      case (k)
        0: step(2, 1, 14, 32'd5, 32'd5, 0, 0, 0, 0, "R10 flags Z C");
        1: step(2, 1, 14, 32'd6, 32'd5, 0, 0, 0, 0, "R10 flags C");
        2: step(0, 1, 14, 32'h7FFF_FFFF, 32'd1, 0, 0, 0, 0, "R10 flags N V");
        default: step(2, 1, 14, 32'd1, 32'd2, 0, 0, 0, 0, "R10 flags N");
      endcase
      for (int c = 0; c < 16; c++)
        step(0, 0, c[3:0], 32'd1, 32'd2, 0, 0, 0, 0, "R10 cond");
    end
    step(2, 1, 14, 32'd6, 32'd5, 0, 0, 0, 0, "R10 HI setup");
    step(0, 1, 8, 32'd0, 32'd0, 0, 0, 0, 0, "R10 HI pass");
    step(0, 1, 8, 32'd1, 32'd1, 0, 0, 0, 0, "R10 HI fail blocks flags");

    // R1-R10 random sweep
    for (int i = 0; i < 1500; i++) begin
      logic [3:0] ro;
      ro = 4'($urandom_range(0, 11));
      step(ro, 1'($urandom), 4'($urandom), $urandom, $urandom, 12'($urandom),
           1'($urandom), ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0), "R1 random");
    end

    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1; mf = 4'b0000;
    chk(flags == 4'b0000, "R11 reset again", {28'd0, flags}, 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule